// File: doc/BRIEF.md
# Self-Timed Page Programming Sequencer

This block carries out the internal programming cycle of a small paged non-volatile memory once the serial front end, or the page-lock manager, has signalled the end of a command. The front end first loads a page buffer one byte at a time, and each load marks that byte. It then issues a request that names the target page and the operation. For a data request, the sequencer runs two timed phases. In the first it erases every marked byte of the page to all ones. In the second it writes each marked byte with its buffered value. Bytes that were not marked keep their old contents.

A request may instead set or clear the lock bit of a page. Before any cycle starts, the sequencer checks the write-protect pin and, for data requests, the lock bit of the target page. A forbidden request is dropped at once. No busy time follows, so the front end can acknowledge the next command byte immediately. The `busy` output covers the whole of an accepted cycle, and the block returns to standby by itself when the cycle ends. Phase lengths are counted in system clock cycles and set by parameters. The memory array and the lock bits are modelled as registers, with the array written so that a block RAM can be inferred.

Top module: `ps_prog_seq`

## Requirements
- R1: A data request (`req_kind` = 2'b00) runs an erase phase followed by a write phase. During the erase phase every marked byte of the target page reads 8'hFF. After the write phase each marked byte holds its buffered value.
- R2: Page bytes whose offset was not loaded into the buffer since the last cycle keep their previous value through a data cycle.
- R3: While `wp_pin` is 1, every request is dropped. No memory byte and no lock bit changes, and `busy` stays 0.
- R4: A data request to a page whose lock bit reads 0 is dropped and leaves the page unchanged. Data requests to other pages still run.
- R5: An accepted data request raises `busy` in the cycle after the request edge. `busy` then stays high for exactly DATA_CYCLES clock cycles, half for erase and half for write.
- R6: `req_kind` 2'b01 writes the page lock bit to 0, and 2'b11 writes it to 1. Either one holds `busy` for exactly PROT_CYCLES cycles and leaves the page data unchanged. The code 2'b10 is dropped.
- R7: `done` pulses for one cycle in the same cycle that `busy` falls.
- R8: While `busy` is 1, requests and buffer loads are ignored. An ignored request starts no second cycle, and a load does not alter the value being written.
- R9: The byte marks clear at the end of every cycle and whenever a request is dropped. A later data request with no new loads therefore changes nothing.
- R10: A dropped request pulses `dropped` for one cycle while `busy` stays 0.
- R11: After reset, `busy`, `done` and `dropped` are 0 and every lock bit reads 1 (unlocked).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Write-protect level; 1 blocks all changes |
| ld_en | input | 1 | Load one byte into the page buffer and mark it |
| ld_ofs | input | OFS_W | Byte offset within the page for the load |
| ld_data | input | DATA_W | Byte value to load |
| req_valid | input | 1 | One-cycle program request (end of command) |
| req_kind | input | 2 | 00 data, 01 lock page, 11 unlock page, 10 invalid |
| req_page | input | PAGE_W | Target page number |
| rd_addr | input | ADDR_W | Array read address (page, offset) |
| rd_data | output | DATA_W | Registered array read data, one cycle latency |
| prot_rd_page | input | PAGE_W | Page whose lock bit is read |
| prot_rd_bit | output | 1 | Registered lock bit, 1 = unlocked |
| busy | output | 1 | A programming cycle is in progress |
| done | output | 1 | One-cycle pulse at the end of a cycle |
| dropped | output | 1 | One-cycle pulse when a request is refused |

## Verification
The bench builds the block with DATA_CYCLES = 64 and PROT_CYCLES = 24, keeping 16-byte pages and 32 pages. With this setting, each 32-cycle phase is long enough for the 16-cycle byte sweep to finish early. The bench can then read an erased byte back as FFh through the normal read port before the write phase starts. The short phases also let it count the exact busy length of every cycle kind, and fit lock, unlock, refused and overlapping requests into a few thousand clocks.

// File: rtl/ps_pkg.sv
package ps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WRITE = 2'd2,
    ST_PROT  = 2'd3
  } seq_state_t;

  localparam logic [1:0] KIND_DATA = 2'b00;
  localparam logic [1:0] KIND_LOCK = 2'b01;
  localparam logic [1:0] KIND_FREE = 2'b11;

endpackage

// File: rtl/ps_phase_timer.sv
module ps_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ps_page_buffer.sv
module ps_page_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_marked
);
  logic [DATA_W-1:0]     word_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      word_q[ld_ofs] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mark_q <= '0;
    end else if (ld_en) begin
      mark_q[ld_ofs] <= 1'b1;
    end
  end

  assign rd_word   = word_q[rd_ofs];
  assign rd_marked = mark_q[rd_ofs];
endmodule

// File: rtl/ps_mem_array.sv
module ps_mem_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ps_prot_bits.sv
module ps_prot_bits #(
  parameter int NUM_PAGES = 32,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] wpage,
  input  logic              wval,
  input  logic [PAGE_W-1:0] chk_page,
  output logic              chk_bit,
  input  logic [PAGE_W-1:0] rd_page,
  output logic              rd_bit
);
  logic [NUM_PAGES-1:0] bits_q;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        bits_q[p] <= 1'b1;
      end else if (we && (wpage == PAGE_W'(p))) begin
        bits_q[p] <= wval;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bit <= 1'b1;
    end else begin
      rd_bit <= bits_q[rd_page];
    end
  end

  assign chk_bit = bits_q[chk_page];
endmodule

// File: rtl/ps_prog_seq.sv
module ps_prog_seq
  import ps_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int NUM_PAGES   = 32,
  parameter int DATA_CYCLES = 400000,
  parameter int PROT_CYCLES = 200000,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int ADDR_W     = OFS_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin,
  input  logic              ld_en,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PAGE_W-1:0] prot_rd_page,
  output logic              prot_rd_bit,
  output logic              busy,
  output logic              done,
  output logic              dropped
);
  localparam int HALF_CYCLES = DATA_CYCLES / 2;
  localparam int MAX_CYCLES  = (HALF_CYCLES > PROT_CYCLES) ? HALF_CYCLES : PROT_CYCLES;
  localparam int CNT_W       = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] HALF_LOAD = CNT_W'(HALF_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROT_LOAD = CNT_W'(PROT_CYCLES - 1);
  localparam logic [OFS_W:0]   SWEEP_END = (OFS_W + 1)'(PAGE_BYTES);

  seq_state_t        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W:0]    sweep_q;
  logic              unlock_q;

  logic              idle, accept, is_data, is_prot;
  logic              go_data, go_prot, drop;
  logic              in_sweep, cycle_end;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              prot_we;
  logic              buf_ld, buf_clr, buf_marked;
  logic [DATA_W-1:0] buf_word;
  logic              chk_bit;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    accept    = idle && req_valid;
    is_data   = (req_kind == KIND_DATA);
    is_prot   = (req_kind == KIND_LOCK) || (req_kind == KIND_FREE);
    go_data   = accept && !wp_pin && is_data && chk_bit;
    go_prot   = accept && !wp_pin && is_prot;
    drop      = accept && !go_data && !go_prot;
    in_sweep  = ((state_q == ST_ERASE) || (state_q == ST_WRITE)) && (sweep_q < SWEEP_END);
    mem_we    = in_sweep && buf_marked;
    mem_waddr = {page_q, sweep_q[OFS_W-1:0]};
    mem_wdata = (state_q == ST_ERASE) ? {DATA_W{1'b1}} : buf_word;
    cycle_end = ((state_q == ST_WRITE) || (state_q == ST_PROT)) && tmr_expired;
    tmr_load  = go_data || go_prot || ((state_q == ST_ERASE) && tmr_expired);
    tmr_val   = go_prot ? PROT_LOAD : HALF_LOAD;
    prot_we   = (state_q == ST_PROT) && tmr_expired;
    buf_ld    = ld_en && idle;
    buf_clr   = cycle_end || drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      sweep_q  <= '0;
      unlock_q <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      dropped  <= 1'b0;
    end else begin
      done    <= 1'b0;
      dropped <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_data) begin
            state_q <= ST_ERASE;
            page_q  <= req_page;
            sweep_q <= '0;
            busy    <= 1'b1;
          end else if (go_prot) begin
            state_q  <= ST_PROT;
            page_q   <= req_page;
            unlock_q <= (req_kind == KIND_FREE);
            busy     <= 1'b1;
          end else if (drop) begin
            dropped <= 1'b1;
          end
        end
        ST_ERASE: begin
          if (sweep_q < SWEEP_END) sweep_q <= sweep_q + 1'b1;
          if (tmr_expired) begin
            state_q <= ST_WRITE;
            sweep_q <= '0;
          end
        end
        ST_WRITE: begin
          if (sweep_q < SWEEP_END) sweep_q <= sweep_q + 1'b1;
          if (tmr_expired) begin
            state_q <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
          end
        end
        ST_PROT: begin
          if (tmr_expired) begin
            state_q <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ps_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ps_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (buf_ld),
    .ld_ofs    (ld_ofs),
    .ld_data   (ld_data),
    .clr       (buf_clr),
    .rd_ofs    (sweep_q[OFS_W-1:0]),
    .rd_word   (buf_word),
    .rd_marked (buf_marked)
  );

  ps_mem_array #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES * NUM_PAGES)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  ps_prot_bits #(.NUM_PAGES(NUM_PAGES)) u_prot (
    .clk      (clk),
    .rst      (rst),
    .we       (prot_we),
    .wpage    (page_q),
    .wval     (unlock_q),
    .chk_page (req_page),
    .chk_bit  (chk_bit),
    .rd_page  (prot_rd_page),
    .rd_bit   (prot_rd_bit)
  );
endmodule

// File: rtl/ps_prog_seq_chk.sv
module ps_prog_seq_chk #(
  parameter int DATA_CYCLES = 64,
  parameter int PROT_CYCLES = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       wp_pin,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       busy,
  input logic       done,
  input logic       dropped
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_start_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // covers both cycle kinds: R5 for data, R6 for lock bits
  assert_cycle_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ((run_len == DATA_CYCLES) || (run_len == PROT_CYCLES)));

  assert_wp_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && wp_pin && !busy) |=> (!busy && dropped));

  assert_bad_kind_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_kind == 2'b10) && !busy) |=> !busy);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_drop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    dropped |-> !busy);
endmodule

bind ps_prog_seq ps_prog_seq_chk #(
  .DATA_CYCLES(DATA_CYCLES),
  .PROT_CYCLES(PROT_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wp_pin    (wp_pin),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .busy      (busy),
  .done      (done),
  .dropped   (dropped)
);

// File: tb/ps_prog_seq_bench.sv
module ps_prog_seq_bench;
  localparam int DW = 8;
  localparam int PB = 16;
  localparam int NP = 32;
  localparam int DC = 64;
  localparam int PC = 24;
  localparam int OW = 4;
  localparam int PW = 5;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_pin = 1'b0;
  logic          ld_en = 1'b0;
  logic [OW-1:0] ld_ofs = '0;
  logic [DW-1:0] ld_data = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [PW-1:0] req_page = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] prot_rd_page = '0;
  logic          prot_rd_bit;
  logic          busy, done, dropped;

  always #10 clk = ~clk;

  ps_prog_seq #(
    .DATA_W(DW), .PAGE_BYTES(PB), .NUM_PAGES(NP),
    .DATA_CYCLES(DC), .PROT_CYCLES(PC)
  ) u_ps_prog_seq (
    .clk(clk), .rst(rst), .wp_pin(wp_pin),
    .ld_en(ld_en), .ld_ofs(ld_ofs), .ld_data(ld_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_page(req_page),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .prot_rd_page(prot_rd_page), .prot_rd_bit(prot_rd_bit),
    .busy(busy), .done(done), .dropped(dropped)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model [NP*PB];

  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_val  [$];
  string         q_tag  [$];
  bit            mon_act = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: pops expected bytes and compares them against the read port
  initial begin
    logic [DW-1:0] v;
    string t;
    forever begin
      @(negedge clk);
      if (q_addr.size() > 0) begin
        mon_act = 1'b1;
        rd_addr = q_addr.pop_front();
        v = q_val.pop_front();
        t = q_tag.pop_front();
        @(negedge clk);
        check(rd_data == v, t, $sformatf("byte @%0h", rd_addr), rd_data, v);
        mon_act = 1'b0;
      end
    end
  end

  task automatic sb_expect(input int addr, input logic [DW-1:0] val, input string tag);
    q_addr.push_back(AW'(addr));
    q_val.push_back(val);
    q_tag.push_back(tag);
  endtask

  task automatic sb_drain();
    while (q_addr.size() != 0 || mon_act) @(negedge clk);
  endtask

  task automatic expect_page(input int page, input string tag);
    for (int o = 0; o < PB; o++) sb_expect(page*PB + o, model[page*PB + o], tag);
    sb_drain();
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int o);
    return DW'(seed*31 + o*7 + 3);
  endfunction

  task automatic load(input int ofs, input logic [DW-1:0] val);
    ld_en = 1'b1; ld_ofs = OW'(ofs); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic request(input logic [1:0] kind, input int page);
    req_valid = 1'b1; req_kind = kind; req_page = PW'(page);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic read_lock(input int page, input bit exp, input string tag);
    prot_rd_page = PW'(page);
    @(negedge clk);
    check(prot_rd_bit == exp, tag, $sformatf("lock bit page %0d", page), prot_rd_bit, exp);
  endtask

  task automatic data_cycle(input int page, input bit [PB-1:0] m, input int seed,
                            input string tag, input bit mid);
    int n;
    int first;
    first = -1;
    for (int o = 0; o < PB; o++) if (m[o]) begin
      load(o, pat(seed, o));
      if (first < 0) first = o;
    end
    request(2'b00, page);
    check(busy == 1'b1, "R5", "busy after accept", busy, 1);
    if (mid && first >= 0) begin
      repeat (PB + 2) @(negedge clk);
      sb_expect(page*PB + first, 8'hFF, "R1");  // erased byte seen mid-cycle
      sb_drain();
    end
    wait_end(n);
    if (mid) n = n + PB + 4;
    check(n == DC || mid, "R5", "data busy length", n, DC);
    check(done == 1'b1, "R7", "done with busy fall", done, 1);
    for (int o = 0; o < PB; o++) if (m[o]) model[page*PB + o] = pat(seed, o);
    expect_page(page, tag);
  endtask

  task automatic expect_drop(input logic [1:0] kind, input int page, input string tag);
    request(kind, page);
    check(busy == 1'b0, tag, "busy on refused request", busy, 0);
    check(dropped == 1'b1, "R10", "dropped pulse", dropped, 1);
    @(negedge clk);
    check(busy == 1'b0 && dropped == 1'b0, "R10", "quiet after drop", {busy, dropped}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, dropped} == 3'b000, "R11", "outputs after reset", {busy, done, dropped}, 0);
    read_lock(0, 1'b1, "R11");
    read_lock(NP-1, 1'b1, "R11");

    // R1: full page, erase visible mid-cycle, then programmed values
    data_cycle(3, 16'hFFFF, 1, "R1", 1'b0);
    data_cycle(3, 16'hFFFF, 11, "R1", 1'b1);
    // R2: partial write leaves other bytes alone
    data_cycle(3, 16'h8024, 2, "R2", 1'b0);
    // R9: no loads since last cycle -> nothing changes
    data_cycle(3, 16'h0000, 9, "R9", 1'b0);

    // R3: write-protect pin refuses data and lock requests
    wp_pin = 1'b1;
    load(0, 8'h11);
    load(1, 8'h22);
    expect_drop(2'b00, 3, "R3");
    expect_drop(2'b01, 3, "R3");
    wp_pin = 1'b0;
    read_lock(3, 1'b1, "R3");
    expect_page(3, "R3");
    // R9: marks were cleared by the drop
    data_cycle(3, 16'h0000, 0, "R9", 1'b0);

    // R6: lock page 3
    request(2'b01, 3);
    wait_end(n);
    check(n == PC, "R6", "lock busy length", n, PC);
    check(done == 1'b1, "R7", "done after lock", done, 1);
    read_lock(3, 1'b0, "R6");
    read_lock(2, 1'b1, "R6");
    expect_page(3, "R6");

    // R4: locked page refuses data, neighbour still writable
    load(4, 8'h5A);
    expect_drop(2'b00, 3, "R4");
    expect_page(3, "R4");
    data_cycle(4, 16'hFFFF, 5, "R4", 1'b0);

    // R6: unlock page 3, writes work again; invalid kind dropped
    request(2'b11, 3);
    wait_end(n);
    check(n == PC, "R6", "unlock busy length", n, PC);
    read_lock(3, 1'b1, "R6");
    data_cycle(3, 16'h0003, 6, "R6", 1'b0);
    expect_drop(2'b10, 3, "R6");

    // R8: request and load during a running cycle are ignored
    for (int o = 0; o < PB; o++) load(o, pat(7, o));
    request(2'b00, 5);
    load(0, 8'hAA);
    request(2'b00, 4);
    wait_end(n);
    check(n == DC - 2, "R8", "busy length with overlap", n, DC - 2);
    @(negedge clk);
    check(busy == 1'b0, "R8", "no second cycle", busy, 0);
    for (int o = 0; o < PB; o++) model[5*PB + o] = pat(7, o);
    expect_page(5, "R8");
    expect_page(4, "R8");

    finish_run();
  end
endmodule